// File: doc/BRIEF.md
# Two-Tone Audio Bit Demodulator

This block turns a stream of signed audio samples carrying two alternating tones into a stream of data bits. Each accepted sample is multiplied by the sample taken half a bit period earlier. The product is smoothed by a first-order recursive low-pass filter. The sign of the filter output gives a one-bit tone decision for every sample, and these decisions are kept in a short history register.

A phase counter recovers the bit clock. It advances a fixed step per sample, and it is pulled one step toward the middle of its range whenever the history shows a clean, two-sample-deep change of tone. Each time the counter wraps, a 2-of-3 vote over the newest history bits decides the line bit. That line bit is then differentially decoded: if it matches the previous line bit the output is 1, and if it differs the output is 0.

Samples enter on a valid/ready input and bits leave on a valid/ready output with a one-entry output slot. The input is ready whenever that slot is empty or is being drained in the same cycle. While a produced bit waits with `out_ready` low, no samples are taken and the waiting bit stays unchanged. Every accepted sample updates all internal state in its own clock cycle, so the bit it produces is visible the cycle after acceptance.

Top module: `afsk_demod`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, the phase counter is 0, the filter state and history are 0, and the previous line bit is 0.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_bit` and `out_valid` hold and the internal state does not move.
- R3: For every accepted sample s, the filter input is (s × d) arithmetically shifted right by 2 in 16-bit signed arithmetic, where d is the sample accepted 4 samples earlier.
- R4: The filter output is y = x_prev + x + (y_prev >>> 1), where x_prev is the previous filter input.
- R5: Each accepted sample shifts one bit into the history register at the least significant end: 1 when y > 0, else 0.
- R6: A transition exists when history bits [1:0] differ from bits [3:2] in both positions. On a transition the phase moves +1 if it is below 32 and −1 otherwise, and this happens before the per-sample step.
- R7: The phase rises by 8 per accepted sample. On reaching 64 or more it wraps modulo 64 and one bit is produced. With no transitions this gives exactly one bit per 8 accepted samples, and idle cycles change nothing.
- R8: The line bit is 1 when at least two of history bits [2:0] are 1.
- R9: `out_bit` is 1 when the new line bit equals the previous one and 0 when they differ. The output appears on the cycle after the deciding sample is accepted.
- R10: The half-bit delay line starts at zero, so the first 4 accepted samples yield a filter input of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample will be taken on this edge if offered |
| in_sample | input | 8 | Signed audio sample |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Consumer takes the bit |
| out_bit | output | 1 | Decoded data bit |

## Verification
The bench builds the block with its default values: 8-bit samples, 8 samples per bit and a phase step of 8, which gives a 64-step phase range with its midpoint at 32. With these values, short constant-level runs are enough to force a transition while the phase sits above the midpoint, and the expected timing of the first bits can be worked out by hand. The same values let tone bursts at 1200 Hz and 2200 Hz, sampled at 9600 samples per second, exercise the whole chain of multiply, filter, vote and differential decoding against a model kept in the bench. Output stalls and idle gaps are also reachable within a few dozen samples.

// File: rtl/afsk_demod_pkg.sv
package afsk_demod_pkg;

  // 2-of-3 majority of the newest tone decisions
  function automatic logic maj3(input logic [2:0] b);
    return (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]);
  endfunction

  // both low bits differ from the pair two positions older
  function automatic logic pair_flip(input logic [3:0] h);
    return (h[1:0] ^ h[3:2]) == 2'b11;
  endfunction

endpackage

// File: rtl/afsk_mix_filter.sv
module afsk_mix_filter #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16,
  parameter int DLY      = 4,
  parameter int HIST_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic        [HIST_W-1:0]   hist_nxt
);

  logic signed [SAMPLE_W-1:0] dly_q [DLY];
  logic signed [ACC_W-1:0]    a_ext, b_ext, prod, x_n, y_n, x_q, y_q;
  logic        [HIST_W-1:0]   hist_q;
  logic                       tone_hi;

  assign a_ext    = ACC_W'(smp);
  assign b_ext    = ACC_W'(dly_q[DLY-1]);
  assign prod     = a_ext * b_ext;
  assign x_n      = prod >>> 2;
  assign y_n      = x_q + x_n + (y_q >>> 1);
  assign tone_hi  = !y_n[ACC_W-1] && (y_n != '0);
  assign hist_nxt = {hist_q[HIST_W-2:0], tone_hi};

  for (genvar i = 0; i < DLY; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dly_q[i] <= '0;
      end else if (adv) begin
        if (i == 0) dly_q[i] <= smp;
        else        dly_q[i] <= dly_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      hist_q <= '0;
    end else if (adv) begin
      x_q    <= x_n;
      y_q    <= y_n;
      hist_q <= hist_nxt;
    end
  end

endmodule

// File: rtl/afsk_clk_recov.sv
module afsk_clk_recov
  import afsk_demod_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int SPB     = 8,
  parameter int STEP    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [3:0]         hist_low,
  output logic               dec_stb,
  output logic               dec_bit,
  output logic [PHASE_W-1:0] phase_q
);

  localparam int PH_MAX = SPB * STEP;
  localparam int PH_MID = PH_MAX / 2;

  logic [PHASE_W-1:0] ph_a, ph_nxt;
  logic [PHASE_W:0]   ph_b;
  logic               flip, wrap;

  assign flip = pair_flip(hist_low);

  always_comb begin
    ph_a = phase_q;
    if (flip) begin
      if (phase_q < PHASE_W'(PH_MID)) ph_a = phase_q + 1'b1;
      else                            ph_a = phase_q - 1'b1;
    end
    ph_b   = {1'b0, ph_a} + (PHASE_W+1)'(STEP);
    wrap   = ph_b >= (PHASE_W+1)'(PH_MAX);
    ph_nxt = wrap ? PHASE_W'(ph_b - (PHASE_W+1)'(PH_MAX)) : PHASE_W'(ph_b);
  end

  assign dec_stb = adv && wrap;
  assign dec_bit = maj3(hist_low[2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)   phase_q <= '0;
    else if (adv) phase_q <= ph_nxt;
  end

endmodule

// File: rtl/afsk_nrzi_out.sv
module afsk_nrzi_out (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_stb,
  input  logic dec_bit,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit
);

  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q    <= 1'b0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
    end else if (dec_stb) begin
      last_q    <= dec_bit;
      out_bit   <= (dec_bit == last_q);
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/afsk_demod.sv
module afsk_demod #(
  parameter int SAMPLE_W        = 8,
  parameter int ACC_W           = 16,
  parameter int SAMPLES_PER_BIT = 8,
  parameter int PHASE_STEP      = 8,
  parameter int PHASE_W         = 8,
  parameter int HIST_W          = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bit
);

  localparam int HALF_BIT = SAMPLES_PER_BIT / 2;

  logic               adv, dec_stb, dec_bit;
  logic [HIST_W-1:0]  hist_nxt;
  logic [PHASE_W-1:0] phase_q;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  afsk_mix_filter #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .DLY(HALF_BIT), .HIST_W(HIST_W)
  ) u_mix (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .smp($signed(in_sample)), .hist_nxt(hist_nxt)
  );

  afsk_clk_recov #(
    .PHASE_W(PHASE_W), .SPB(SAMPLES_PER_BIT), .STEP(PHASE_STEP)
  ) u_rec (
    .clk(clk), .rst_n(rst_n), .adv(adv), .hist_low(hist_nxt[3:0]),
    .dec_stb(dec_stb), .dec_bit(dec_bit), .phase_q(phase_q)
  );

  afsk_nrzi_out u_out (
    .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb), .dec_bit(dec_bit),
    .out_ready(out_ready), .out_valid(out_valid), .out_bit(out_bit)
  );

endmodule

// File: rtl/afsk_demod_chk.sv
module afsk_demod_chk #(
  parameter int PHASE_W = 8,
  parameter int PH_MAX  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_bit,
  input logic [PHASE_W-1:0] phase
);

  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R2

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R2

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PHASE_W'(PH_MAX)); // R7

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(phase)); // R7

  AST_PHASE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !$stable(phase)); // R6

  AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R9

endmodule

bind afsk_demod afsk_demod_chk #(
  .PHASE_W(PHASE_W), .PH_MAX(SAMPLES_PER_BIT * PHASE_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
  .phase(phase_q)
);

// File: tb/test_afsk_demod.sv
module test_afsk_demod;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       out_ready = 1'b1;
  logic [7:0] in_sample = '0;
  logic       in_ready, out_valid, out_bit;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  afsk_demod i_afsk_demod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit)
  );

  // independent model of the requirements
  shortint m_dly [4];
  shortint m_x, m_y;
  logic [7:0] m_h;
  int  m_ph;
  bit  m_last;

  task automatic model_clear();
    for (int i = 0; i < 4; i++) m_dly[i] = 0;
    m_x = 0; m_y = 0; m_h = 0; m_ph = 0; m_last = 0;
  endtask

  task automatic model_step(input int s, output bit got, output bit b);
    shortint p, xn, yn;
    bit v;
    p  = shortint'(s * int'(m_dly[3]));
    xn = p >>> 2;
    yn = shortint'(int'(m_x) + int'(xn) + int'(m_y >>> 1));
    for (int i = 3; i > 0; i--) m_dly[i] = m_dly[i-1];
    m_dly[0] = shortint'(s);
    m_x = xn; m_y = yn;
    m_h = {m_h[6:0], (yn > 0)};
    if (((m_h ^ (m_h >> 2)) & 8'd3) == 8'd3) m_ph += (m_ph < 32) ? 1 : -1;
    m_ph += 8;
    got = 0; b = 0;
    if (m_ph >= 64) begin
      m_ph -= 64;
      v = ((m_h[0] + m_h[1] + m_h[2]) >= 2);
      b = (v == m_last);
      m_last = v;
      got = 1;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  // offers one sample, returns output seen the cycle after acceptance
  task automatic push(input int s, output bit got, output bit b);
    @(negedge clk);
    in_sample = s[7:0];
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got = out_valid;
    b   = out_bit;
  endtask

  task automatic push_cmp(input int s, input string req);
    bit g, b, mg, mb;
    push(s, g, b);
    model_step(s, mg, mb);
    check(g == mg, req, "bit strobe", int'(g), int'(mg));
    if (mg && g) check(b == mb, req, "bit value", int'(b), int'(mb));
  endtask

  task automatic t_reset();
    do_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_silence();
    bit g, b;
    int first;
    do_reset();
    first = -1;
    for (int i = 1; i <= 24; i++) begin
      push(0, g, b);
      if (g) begin
        if (first < 0) first = i;
        check(b == 1'b1, "R9", "silence gives repeated line bit", int'(b), 1);
      end
      check(g == (i % 8 == 0), "R7", "one bit per 8 samples", int'(g), int'(i % 8 == 0));
    end
    check(first == 8, "R1", "first bit from zero phase", first, 8);
  endtask

  task automatic t_dc_step();
    bit g, b;
    do_reset();
    for (int i = 1; i <= 17; i++) begin
      push(100, g, b);
      if (i == 8)  check(g == 1'b0, "R6", "nudge delays first bit", int'(g), 0);
      if (i == 9)  begin
        check(g == 1'b1, "R10", "first bit at sample 9", int'(g), 1);
        check(b == 1'b0, "R8", "vote 1 after 0 gives 0", int'(b), 0);
      end
      if (i == 17) begin
        check(g == 1'b1, "R7", "second bit at sample 17", int'(g), 1);
        check(b == 1'b1, "R9", "repeat line bit gives 1", int'(b), 1);
      end
    end
  endtask

  task automatic t_tones();
    real ph;
    real f;
    logic [7:0] lf;
    int s;
    do_reset();
    ph = 0.0;
    lf = 8'hA5;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      f = lf[0] ? 1200.0 : 2200.0;
      for (int j = 0; j < 8; j++) begin
        s = $rtoi($floor(100.0 * $sin(ph) + 0.5));
        ph = ph + 2.0 * 3.14159265358979 * f / 9600.0;
        push_cmp(s, "R3 R4 R5 R8");
      end
    end
  endtask

  task automatic t_alternating();
    do_reset();
    for (int i = 0; i < 64; i++)
      push_cmp(((i / 3) % 2) ? -90 : 70, "R4 R6");
  endtask

  task automatic t_backpressure();
    bit g, b;
    do_reset();
    out_ready = 1'b0;
    for (int i = 0; i < 8; i++) push(0, g, b);
    check(g == 1'b1, "R2", "bit waiting", int'(g), 1);
    check(in_ready == 1'b0, "R2", "in_ready low while full", int'(in_ready), 0);
    in_sample = 8'd50; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2", "bit held", int'(out_valid), 1);
    check(out_bit == 1'b1, "R2", "held bit value", int'(out_bit), 1);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "bit drained", int'(out_valid), 0);
    for (int i = 1; i <= 8; i++) begin
      push(0, g, b);
      check(g == (i == 8), "R2", "stalled sample not taken", int'(g), int'(i == 8));
    end
  endtask

  task automatic t_idle_gaps();
    bit g, b, mg, mb;
    do_reset();
    for (int i = 0; i < 24; i++) begin
      repeat (i % 4) @(negedge clk);
      push(100 - 9 * i, g, b);
      model_step(100 - 9 * i, mg, mb);
      check(g == mg, "R7", "idle cycles change nothing", int'(g), int'(mg));
      if (g && mg) check(b == mb, "R7", "bit after gaps", int'(b), int'(mb));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_silence();
    t_dc_step();
    t_tones();
    t_alternating();
    t_backpressure();
    t_idle_gaps();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule